// File: doc/BRIEF.md
# Throttle ratio search engine

This block picks the pair of duty counts that drives a clock-suspension throttle as close as possible to a requested frequency. A throttle of this kind suspends the core for ON units and lets it run for OFF units, so the core's effective frequency is the stock frequency scaled by OFF / (ON + OFF). Given a target frequency and the stock frequency, both in kHz, and a limit on the total period ON + OFF, the engine searches every allowed total. It returns the ON and OFF counts of the best candidate and the frequency that candidate achieves.

The search is sequential. Each candidate total needs two divisions, and both run on one shared shift-subtract divider, one quotient bit per cycle. The totals are tried from the largest allowed value down to one. A candidate also wins when its error only equals the best error so far, so among equally good ratios the shortest period wins and throttle latency stays low.

A caller presents the operands and pulses `start`. The engine copies the operands on that edge, raises `busy`, and signals the end of the search with a one-cycle `done`. The result outputs hold their values until the next search finishes. A stock frequency of zero cannot be divided by, so the engine ends at once and raises `fault`.

Top module: `thr_ratio_search`

States: `ST_IDLE` (waiting), `ST_INIT` (check operands), `ST_OFF_GO` / `ST_OFF_WAIT` (launch and collect the OFF division), `ST_FRQ_GO` / `ST_FRQ_WAIT` (launch and collect the achieved-frequency division), `ST_JUDGE` (compare errors), `ST_STEP` (next total or finish), `ST_DONE` (result pulse). The transitions are:
- IDLE to INIT on start.
- INIT to DONE when the stock frequency or the total limit is zero, otherwise INIT to OFF_GO.
- OFF_GO to OFF_WAIT, then OFF_WAIT to FRQ_GO when the divider finishes.
- FRQ_GO to FRQ_WAIT, then FRQ_WAIT to JUDGE when the divider finishes.
- JUDGE to STEP.
- STEP to DONE at total 1, otherwise STEP back to OFF_GO.
- DONE to IDLE.

## Requirements
- R1: After reset, `done`, `busy` and `fault` are 0 and `on_cnt`, `off_cnt` and `ach_khz` are all 0.
- R2: For each candidate total i, OFF is the low 8 bits of floor(target·i / stock), where the product is kept to 32 bits. ON is (i − OFF) modulo 256. So ON + OFF modulo 256 equals the total and is never zero in a reported result.
- R3: A candidate achieves floor(stock·OFF / i) with a 32-bit product. The reported `ach_khz` is the value achieved by the chosen candidate.
- R4: A candidate replaces the best so far when |achieved − target| is less than or equal to the best error. Totals are tried from the limit down to 1, so a tie goes to the smaller total.
- R5: Before any candidate is tried, the best is set to achieved = stock, OFF = 1, ON = 0. With a total limit of 0, these values are the result.
- R6: A `max_total` above 255 behaves exactly like 255.
- R7: With `stock_khz` equal to 0, `done` and `fault` are high two cycles after start is accepted. The result is achieved = 0, OFF = 1 and ON = 0.
- R8: `done` is high for exactly one cycle per search.
- R9: A `start` while `busy` is high is ignored. The search in progress completes with the operands copied when it was accepted.
- R10: `busy` is high from the cycle after start is accepted through the `done` cycle, and low in the cycle after `done`.
- R11: The result outputs and `fault` change only on the edge that raises `done`, and `fault` is 0 after a search with a nonzero stock frequency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; accepted only when `busy` is low |
| target_khz | input | 32 | Requested frequency in kHz |
| stock_khz | input | 32 | Unthrottled frequency in kHz |
| max_total | input | 16 | Upper limit on ON + OFF, clamped to 255 |
| done | output | 1 | One-cycle end-of-search pulse |
| busy | output | 1 | Search in progress |
| fault | output | 1 | Last search had a zero stock frequency |
| on_cnt | output | 8 | Chosen suspend (ON) count |
| off_cnt | output | 8 | Chosen run (OFF) count |
| ach_khz | output | 32 | Frequency achieved by the chosen counts |

## Verification
The bench aims at ties. Half the stock frequency is reached exactly by every even total, so an engine with a strict comparison would report a large total instead of ON = OFF = 1. A target above stock makes OFF exceed the total and ON wrap, which catches a saturating or widened subtraction. A limit of 300 must give the same answer as 255, so a missing clamp or one that truncates to 8 bits shows up as a different pair. A zero limit must give the stock frequency with OFF = 1, a zero stock frequency must fault without hanging in the divider, and a start issued mid-search with other operands must leave the result untouched.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    localparam int FRQ_W = 32;
    localparam int CNT_W = 8;
    localparam int LIM_W = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INIT,
        ST_OFF_GO,
        ST_OFF_WAIT,
        ST_FRQ_GO,
        ST_FRQ_WAIT,
        ST_JUDGE,
        ST_STEP,
        ST_DONE
    } tsr_state_e;

endpackage

// File: rtl/tsr_divider.sv
// Restoring shift-subtract divider, one quotient bit per cycle.
module tsr_divider #(
    parameter int W = 32,
    localparam int CNTW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic         fin
);

    logic [W:0]      rem_q;
    logic [W-1:0]    quo_q;
    logic [W-1:0]    den_q;
    logic [CNTW-1:0] cnt_q;
    logic            fin_q;

    logic [W:0]      shifted;
    logic [W+1:0]    trial;
    logic            fits;

    always_comb begin
        shifted = {rem_q[W-1:0], quo_q[W-1]};
        trial   = {1'b0, shifted} - {2'b00, den_q};
        fits    = ~trial[W+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            fin_q <= 1'b0;
        end else if (go) begin
            rem_q <= '0;
            quo_q <= num;
            den_q <= den;
            cnt_q <= CNTW'(W);
            fin_q <= 1'b0;
        end else if (cnt_q != '0) begin
            rem_q <= fits ? trial[W:0] : shifted;
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            fin_q <= (cnt_q == CNTW'(1));
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign quo = quo_q;
    assign fin = fin_q;

endmodule

// File: rtl/tsr_judge.sv
// Error of a candidate against the target, and the keep-or-replace decision.
module tsr_judge #(
    parameter int FW = 32
) (
    input  logic [FW-1:0] cand_frq,
    input  logic [FW-1:0] target,
    input  logic [FW-1:0] best_err,
    output logic [FW-1:0] cand_err,
    output logic          take
);

    always_comb begin
        if (cand_frq >= target) begin
            cand_err = cand_frq - target;
        end else begin
            cand_err = target - cand_frq;
        end
        // less-or-equal: a later, shorter total wins a tie
        take = (cand_err <= best_err);
    end

endmodule

// File: rtl/thr_ratio_search.sv
module thr_ratio_search
    import tsr_pkg::*;
#(
    parameter int FW = tsr_pkg::FRQ_W,
    parameter int CW = tsr_pkg::CNT_W,
    parameter int MW = tsr_pkg::LIM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   target_khz,
    input  logic [31:0]   stock_khz,
    input  logic [15:0]   max_total,
    output logic          done,
    output logic          busy,
    output logic          fault,
    output logic [7:0]    on_cnt,
    output logic [7:0]    off_cnt,
    output logic [31:0]   ach_khz
);

    localparam int              CAP     = (1 << CW) - 1;
    localparam logic [CW-1:0]   IDX_ONE = CW'(1);
    localparam logic [MW-1:0]   LIM_CAP = MW'(CAP);

    tsr_state_e state_q, state_d;

    logic [FW-1:0] tgt_q, stk_q;
    logic [CW-1:0] idx_q;
    logic [CW-1:0] cand_off_q, cand_on_q;
    logic [FW-1:0] cand_frq_q;
    logic [CW-1:0] best_off_q, best_on_q;
    logic [FW-1:0] best_frq_q, best_err_q;
    logic [CW-1:0] res_off_q, res_on_q;
    logic [FW-1:0] res_frq_q;
    logic          fault_q;

    logic [CW-1:0] lim_idx;
    logic [FW-1:0] init_err;
    logic          accept;

    logic          div_go;
    logic [FW-1:0] div_num, div_den;
    logic [FW-1:0] div_quo;
    logic          div_fin;
    logic [FW-1:0] prod_off, prod_frq;

    logic [FW-1:0] cand_err;
    logic          take;

    // ---------------- operand preparation ----------------
    always_comb begin
        lim_idx  = (max_total > LIM_CAP) ? CW'(CAP) : max_total[CW-1:0];
        init_err = (stock_khz >= target_khz) ? (stock_khz - target_khz)
                                             : (target_khz - stock_khz);
        accept   = start && (state_q == ST_IDLE);
        prod_off = tgt_q * {{(FW-CW){1'b0}}, idx_q};
        prod_frq = stk_q * {{(FW-CW){1'b0}}, cand_off_q};
        div_go   = (state_q == ST_OFF_GO) || (state_q == ST_FRQ_GO);
        div_num  = (state_q == ST_OFF_GO) ? prod_off : prod_frq;
        div_den  = (state_q == ST_OFF_GO) ? stk_q : {{(FW-CW){1'b0}}, idx_q};
    end

    tsr_divider #(.W(FW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_quo),
        .fin   (div_fin)
    );

    tsr_judge #(.FW(FW)) u_judge (
        .cand_frq (cand_frq_q),
        .target   (tgt_q),
        .best_err (best_err_q),
        .cand_err (cand_err),
        .take     (take)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_INIT;
            ST_INIT:     state_d = ((stk_q == '0) || (idx_q == '0)) ? ST_DONE : ST_OFF_GO;
            ST_OFF_GO:   state_d = ST_OFF_WAIT;
            ST_OFF_WAIT: if (div_fin) state_d = ST_FRQ_GO;
            ST_FRQ_GO:   state_d = ST_FRQ_WAIT;
            ST_FRQ_WAIT: if (div_fin) state_d = ST_JUDGE;
            ST_JUDGE:    state_d = ST_STEP;
            ST_STEP:     state_d = (idx_q == IDX_ONE) ? ST_DONE : ST_OFF_GO;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q      <= '0;
            stk_q      <= '0;
            idx_q      <= '0;
            cand_off_q <= '0;
            cand_on_q  <= '0;
            cand_frq_q <= '0;
            best_off_q <= '0;
            best_on_q  <= '0;
            best_frq_q <= '0;
            best_err_q <= '0;
            res_off_q  <= '0;
            res_on_q   <= '0;
            res_frq_q  <= '0;
            fault_q    <= 1'b0;
        end else begin
            if (accept) begin
                tgt_q      <= target_khz;
                stk_q      <= stock_khz;
                idx_q      <= lim_idx;
                best_frq_q <= stock_khz;
                best_off_q <= IDX_ONE;
                best_on_q  <= '0;
                best_err_q <= init_err;
            end
            if ((state_q == ST_OFF_WAIT) && div_fin) begin
                cand_off_q <= div_quo[CW-1:0];
                cand_on_q  <= idx_q - div_quo[CW-1:0];
            end
            if ((state_q == ST_FRQ_WAIT) && div_fin) begin
                cand_frq_q <= div_quo;
            end
            if ((state_q == ST_JUDGE) && take) begin
                best_off_q <= cand_off_q;
                best_on_q  <= cand_on_q;
                best_frq_q <= cand_frq_q;
                best_err_q <= cand_err;
            end
            if ((state_q == ST_STEP) && (idx_q != IDX_ONE)) begin
                idx_q <= idx_q - 1'b1;
            end
            if ((state_d == ST_DONE) && (state_q != ST_DONE)) begin
                res_off_q <= best_off_q;
                res_on_q  <= best_on_q;
                res_frq_q <= best_frq_q;
                fault_q   <= (stk_q == '0);
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        done    = (state_q == ST_DONE);
        busy    = (state_q != ST_IDLE);
        fault   = fault_q;
        on_cnt  = res_on_q;
        off_cnt = res_off_q;
        ach_khz = res_frq_q;
    end

endmodule

// File: rtl/thr_ratio_search_chk.sv
module thr_ratio_search_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [31:0] stock_khz,
    input logic        done,
    input logic        busy,
    input logic        fault,
    input logic [7:0]  on_cnt,
    input logic [7:0]  off_cnt,
    input logic [31:0] ach_khz
);

    logic [7:0] total_wrap;
    assign total_wrap = on_cnt + off_cnt;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R8

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                              // R10

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));                        // R10

    AST_ZERO_STOCK_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (stock_khz == 32'd0)) |=> ##1 (done && fault)); // R7

    AST_TOTAL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (total_wrap != 8'd0));                               // R2

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ach_khz) || !$stable(on_cnt) || !$stable(off_cnt) || !$stable(fault))
            |-> done);                                                // R11

endmodule

bind thr_ratio_search thr_ratio_search_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stock_khz (stock_khz),
    .done      (done),
    .busy      (busy),
    .fault     (fault),
    .on_cnt    (on_cnt),
    .off_cnt   (off_cnt),
    .ach_khz   (ach_khz)
);

// File: tb/thr_ratio_search_bench.sv
module thr_ratio_search_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] target_khz = '0;
    logic [31:0] stock_khz = '0;
    logic [15:0] max_total = '0;
    logic        done, busy, fault;
    logic [7:0]  on_cnt, off_cnt;
    logic [31:0] ach_khz;

    always #2 clk = ~clk;   // 250 MHz

    thr_ratio_search u_thr_ratio_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .target_khz (target_khz),
        .stock_khz  (stock_khz),
        .max_total  (max_total),
        .done       (done),
        .busy       (busy),
        .fault      (fault),
        .on_cnt     (on_cnt),
        .off_cnt    (off_cnt),
        .ach_khz    (ach_khz)
    );

    typedef struct {
        logic [7:0]  on;
        logic [7:0]  off;
        logic [31:0] frq;
        logic        flt;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   n_seen = 0;
    bit   finished = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] adiff(input logic [31:0] a, input logic [31:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    // Reference search written from the requirements
    function automatic exp_t model(input logic [31:0] t, input logic [31:0] s,
                                   input int unsigned m, input string tag);
        exp_t r;
        logic [31:0] best_e;
        r.on = 8'd0; r.off = 8'd1; r.frq = s; r.flt = 1'b0; r.tag = tag;
        if (m > 255) m = 255;
        if (s == 0) begin
            r.flt = 1'b1;
            return r;
        end
        best_e = adiff(s, t);
        for (int i = int'(m); i > 0; i--) begin
            logic [31:0] ii, p, fr, e;
            logic [7:0]  o, n;
            ii = 32'(i);
            p  = t * ii;
            o  = 8'(p / s);
            n  = ii[7:0] - o;
            fr = (s * {24'd0, o}) / ii;
            e  = adiff(fr, t);
            if (e <= best_e) begin
                best_e = e; r.on = n; r.off = o; r.frq = fr;
            end
        end
        return r;
    endfunction

    // Driver: push expectation, pulse start, optionally poke start mid-search
    task automatic run_search(input logic [31:0] t, input logic [31:0] s,
                              input logic [15:0] m, input bit poke, input string tag);
        int want;
        exp_q.push_back(model(t, s, int'(m), tag));
        want = n_seen + 1;
        @(negedge clk);
        target_khz = t; stock_khz = s; max_total = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10", "busy after accept", {31'd0, busy}, 32'd1);
        if (poke) begin
            repeat (6) @(negedge clk);
            target_khz = 32'd5; stock_khz = 32'd11; max_total = 16'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R9", "busy during ignored start", {31'd0, busy}, 32'd1);
        end
        while (n_seen < want) @(negedge clk);
    endtask

    // Monitor: pop and compare on done
    bit prev_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) begin
                chk("R8", "done single cycle", {31'd0, done}, 32'd0);
                chk("R10", "busy after done", {31'd0, busy}, 32'd0);
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk("R8", "unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(e.tag, "on_cnt",  {24'd0, on_cnt},  {24'd0, e.on});
                    chk(e.tag, "off_cnt", {24'd0, off_cnt}, {24'd0, e.off});
                    chk(e.tag, "ach_khz", ach_khz, e.frq);
                    chk(e.tag, "fault",   {31'd0, fault}, {31'd0, e.flt});
                end
                n_seen++;
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete actual=hang expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "done",    {31'd0, done},  32'd0);
        chk("R1", "busy",    {31'd0, busy},  32'd0);
        chk("R1", "fault",   {31'd0, fault}, 32'd0);
        chk("R1", "on_cnt",  {24'd0, on_cnt},  32'd0);
        chk("R1", "off_cnt", {24'd0, off_cnt}, 32'd0);
        chk("R1", "ach_khz", ach_khz, 32'd0);

        // R4: half of stock, every even total is exact; shortest must win
        run_search(32'd100000, 32'd200000, 16'd10, 1'b0, "R4");
        // R2/R3: general ratio
        run_search(32'd73000, 32'd200000, 16'd40, 1'b0, "R3");
        // R2: target above stock, ON wraps
        run_search(32'd250000, 32'd200000, 16'd5, 1'b0, "R2");
        // R5: zero limit keeps initial best
        run_search(32'd50000, 32'd200000, 16'd0, 1'b0, "R5");
        // R7: zero stock faults
        run_search(32'd1234, 32'd0, 16'd20, 1'b0, "R7");
        // R11: fault cleared by a good search; small operands
        run_search(32'd7, 32'd9, 16'd12, 1'b0, "R11");
        // R9: start while busy ignored
        run_search(32'd41000, 32'd133000, 16'd30, 1'b1, "R9");
        // R4: target equal to stock, ties down to total 1
        run_search(32'd90000, 32'd90000, 16'd8, 1'b0, "R4");
        // R6: full limit and an over-range limit give the same answer
        run_search(32'd33333, 32'd233000, 16'd255, 1'b0, "R6");
        run_search(32'd33333, 32'd233000, 16'd300, 1'b0, "R6");

        repeat (4) @(negedge clk);
        chk("R11", "outputs held, no extra done", 32'(exp_q.size()), 32'd0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule